// File: doc/BRIEF.md
# Write-Through Snooping Invalidate Cache Controller

This block is a small direct-mapped cache controller for one processor that sits on a shared, atomic snooping bus. Every line is either Valid or Invalid. A line holds one data word. The line index is the low `IDX_W` address bits and the tag is the remaining upper bits. Read misses fetch the word over the bus and fill the line. Reads that hit are answered locally and make no bus traffic. Every write goes out on the bus as a bus write, hit or miss. A write that hits also refreshes the local copy. A write that misses does not allocate a line.

The controller watches the write traffic of other bus agents. When a snooped write matches a resident line, that line drops to Invalid, so the next local read fetches the new value from memory. The tag compare for a snoop uses the address in the cycle it appears. Traffic seen during the controller's own bus tenure (`bus_req` and `bus_gnt` both high) is its own and is ignored.

The processor side uses two valid/ready streams. A request is accepted on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is high only while the controller is idle, so one operation is in flight at a time. A response is offered on `cpu_rsp_valid`, and its data stays stable until a cycle with `cpu_rsp_ready` high consumes it. The bus side is a request/grant pair. `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` are held steady until the cycle in which `bus_ack` completes the transaction. Read data is taken from `bus_rdata` in that same cycle.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, `cpu_rsp_valid` is 0 and `bus_req` is 0, so the first read of any address misses.
- R2: A read that misses raises `bus_req` two cycles after acceptance, with `bus_cmd`=0 (read) and the request address. The cycle after `bus_ack` it offers `bus_rdata` as the response and holds the line Valid with that word.
- R3: A read that hits offers the cached word on `cpu_rsp_valid` two cycles after acceptance, and `bus_req` stays 0 for the whole operation.
- R4: Every write, hit or miss, raises `bus_req` with `bus_cmd`=1 (write), the request address and the write data. The response (data 0) follows the cycle after `bus_ack`.
- R5: A write that misses leaves the cache unchanged: a later read of that address misses.
- R6: A write that hits replaces the cached word once its bus write completes: a later read hits and returns the written data.
- R7: A snooped write (`snp_valid`=1, `snp_write`=1) to a resident line makes it Invalid. A snooped read, or a snooped write with the same index but a different tag, leaves the line as it was.
- R8: Snoop traffic in cycles where `bus_req` and `bus_gnt` are both high is ignored, so the controller's own write does not invalidate its own line.
- R9: A snooped write to the line that a read is looking up in the same cycle wins: the read becomes a miss and fetches from the bus.
- R10: Once raised, `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` stay stable until a cycle with `bus_ack`=1, and `bus_req` is 0 in the cycle after that.
- R11: `cpu_req_ready` is 0 from acceptance until the response is consumed. While `cpu_rsp_valid` is high and `cpu_rsp_ready` is low, the response and its data stay unchanged.
- R12: A fill replaces a line of the same index but a different tag, so a later read of the displaced address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request offered |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response offered |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Read data (0 for writes) |
| bus_req | output | 1 | Bus transaction requested / in progress |
| bus_gnt | input | 1 | Bus tenure granted to this controller |
| bus_cmd | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| snp_valid | input | 1 | A bus transaction is visible to snoop |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped transaction address |

## Verification
A read lookup and a snooped write to the same line can land in the same cycle. The bench provokes this by driving a foreign write to the address in the cycle after the read is accepted. It expects the read to turn into a bus read that returns the value the foreign agent wrote, never the stale cached word. A second overlap comes from the bench echoing the controller's own bus transaction onto the snoop inputs while it holds the grant. A follow-up read must still hit with the freshly written data. The reference model decides hit or miss per access, and on every clock the bench compares `bus_req` against whether the model expects a bus phase.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_BUS,
    ST_RESP
  } ctl_state_e;

  localparam logic CMD_READ  = 1'b0;
  localparam logic CMD_WRITE = 1'b1;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_hit,
  input  logic              inv_en,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0] lk_idx, sn_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, sn_tag, wr_tag;
  logic             lk_raw;
  logic [LINES-1:0] sn_match;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
  assign sn_idx = sn_addr[IDX_W-1:0];
  assign sn_tag = sn_addr[ADDR_W-1:IDX_W];
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:IDX_W];

  // processor-side lookup; an invalidation landing this cycle on the same line wins
  assign lk_raw  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_hit  = lk_raw && !(inv_en && (sn_idx == lk_idx));
  assign lk_data = data_q[lk_idx];

  // snoop-side compare, one comparator per line
  for (genvar i = 0; i < LINES; i++) begin : g_snoop_cmp
    assign sn_match[i] = valid_q[i] && (sn_idx == IDX_W'(i)) && (tag_q[i] == sn_tag);
  end
  assign sn_hit = |sn_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (fill_en) valid_q[wr_idx] <= 1'b1;
      if (inv_en)  valid_q[sn_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end else if (upd_en) begin
      data_q[wr_idx] <= wr_data;
    end
  end

  // R7
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_en) |=> !valid_q[$past(sn_idx)]);

  // R2
  fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_en) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/wtc_snoop_gate.sv
module wtc_snoop_gate (
  input  logic snp_valid,
  input  logic snp_write,
  input  logic own_tenure,
  input  logic sn_hit,
  output logic inv_en
);
  // only a foreign write that matches a resident line clears it
  assign inv_en = snp_valid && snp_write && !own_tenure && sn_hit;
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              fill_en,
  output logic              upd_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  ctl_state_e        state_q, state_d;
  logic              req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              accept, read_hit, bus_done;

  assign accept   = (state_q == ST_IDLE) && cpu_req_valid;
  assign read_hit = (state_q == ST_LOOK) && !req_wr_q && lk_hit;
  assign bus_done = (state_q == ST_BUS) && bus_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cpu_req_valid) state_d = ST_LOOK;
      ST_LOOK: state_d = read_hit ? ST_RESP : ST_BUS;
      ST_BUS:  if (bus_ack) state_d = ST_RESP;
      ST_RESP: if (cpu_rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_wr_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        req_wr_q    <= cpu_req_write;
        req_addr_q  <= cpu_req_addr;
        req_wdata_q <= cpu_req_wdata;
      end
      if (read_hit) rsp_data_q <= lk_data;
      else if (bus_done) rsp_data_q <= req_wr_q ? '0 : bus_rdata;
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_rdata = rsp_data_q;

  assign bus_req   = (state_q == ST_BUS);
  assign bus_cmd   = req_wr_q ? CMD_WRITE : CMD_READ;
  assign bus_addr  = req_addr_q;
  assign bus_wdata = req_wdata_q;

  // line-store write port: fills on read completion, refresh on write hit
  assign lk_addr = req_addr_q;
  assign wr_addr = req_addr_q;
  assign wr_data = req_wr_q ? req_wdata_q : bus_rdata;
  assign fill_en = bus_done && !req_wr_q;
  assign upd_en  = bus_done && req_wr_q && lk_hit;

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata)));

  // R10
  bus_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_hit |=> (cpu_rsp_valid && !bus_req));

  // R4
  wr_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOOK) && req_wr_q) |=> (bus_req && bus_cmd == CMD_WRITE));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr
);
  logic [ADDR_W-1:0] lk_addr, wr_addr;
  logic [DATA_W-1:0] lk_data, wr_data;
  logic              lk_hit, sn_hit, inv_en, fill_en, upd_en, own_tenure;

  assign own_tenure = bus_req && bus_gnt;

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .upd_en(upd_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  wtc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .sn_addr(snp_addr), .sn_hit(sn_hit), .inv_en(inv_en),
    .fill_en(fill_en), .upd_en(upd_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  wtc_snoop_gate u_gate (
    .snp_valid(snp_valid), .snp_write(snp_write),
    .own_tenure(own_tenure), .sn_hit(sn_hit), .inv_en(inv_en)
  );

  // R8
  own_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |-> !inv_en);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_req_ready && !cpu_rsp_valid && !bus_req));
endmodule

// File: tb/test_wt_snoop_cache.sv
`timescale 1ns/100ps
module test_wt_snoop_cache;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic bus_req, bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 0, bus_ack = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_write = 0;
  logic [AW-1:0] snp_addr = '0;

  always #2.5 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) i_wt_snoop_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr)
  );

  // reference model: line state by index, plus a memory image
  logic          m_valid [NL];
  logic [AW-IW-1:0] m_tag [NL];
  logic [DW-1:0] m_data [NL];
  logic [DW-1:0] mem [256];
  bit bus_expected = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [AW-1:0] a);
    return m_valid[a[IW-1:0]] && (m_tag[a[IW-1:0]] == a[AW-1:IW]);
  endfunction

  // every clock: bus activity must match the model's expectation
  always @(posedge clk) begin
    if (rst_n && !done && !bus_expected && bus_req) begin
      n_checks++;
      n_errors++;
      $display("FAIL R3 unexpected bus request: actual=1 expected=0");
    end
  end

  task automatic model_snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem[a[7:0]] = d;
    if (m_hit(a)) m_valid[a[IW-1:0]] = 1'b0;
  endtask

  // foreign bus transaction seen on the snoop inputs for one cycle
  task automatic snoop(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_write = wr; snp_addr = a;
    if (wr) model_snoop(a, d);
    @(negedge clk);
    snp_valid = 0; snp_write = 0;
  endtask

  // one processor operation; exp_hit: 1 hit, 0 miss (reads only)
  task automatic do_op(input string req, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input int exp_hit, input int gdly,
                       input int rdly, input bit snoop_lk, input logic [DW-1:0] snd);
    logic [DW-1:0] exp;
    bit obs_bus;
    @(negedge clk);
    check("R11", "ready before request", {31'd0, cpu_req_ready}, 1);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    check("R11", "ready while busy", {31'd0, cpu_req_ready}, 0);
    if (snoop_lk) begin
      snp_valid = 1; snp_write = 1; snp_addr = a;
      model_snoop(a, snd);
    end
    @(negedge clk);
    snp_valid = 0; snp_write = 0;
    obs_bus = bus_req;
    if (!wr) check(req, "hit/miss (1=bus)", {31'd0, obs_bus}, exp_hit ? 0 : 1);
    else check("R4", "write goes to bus", {31'd0, obs_bus}, 1);
    if (!obs_bus) begin
      exp = m_data[a[IW-1:0]];
    end else begin
      bus_expected = 1;
      check(wr ? "R4" : "R2", "bus command", {31'd0, bus_cmd}, {31'd0, wr});
      check(wr ? "R4" : "R2", "bus address", {16'd0, bus_addr}, {16'd0, a});
      if (wr) check("R4", "bus write data", bus_wdata, wd);
      for (int k = 0; k < gdly; k++) begin
        @(negedge clk);
        check("R10", "request held", {31'd0, bus_req}, 1);
        check("R10", "address held", {16'd0, bus_addr}, {16'd0, a});
      end
      bus_gnt = 1;
      snp_valid = 1; snp_write = wr; snp_addr = a;   // own transaction echoed
      @(negedge clk);
      bus_ack = 1;
      bus_rdata = wr ? 32'hDEAD_BEEF : mem[a[7:0]];
      @(negedge clk);
      bus_gnt = 0; bus_ack = 0; snp_valid = 0; snp_write = 0; bus_rdata = '0;
      check("R10", "request dropped after ack", {31'd0, bus_req}, 0);
      bus_expected = 0;
      if (wr) begin
        mem[a[7:0]] = wd;
        if (m_hit(a)) m_data[a[IW-1:0]] = wd;
        exp = '0;
      end else begin
        m_valid[a[IW-1:0]] = 1; m_tag[a[IW-1:0]] = a[AW-1:IW];
        m_data[a[IW-1:0]] = mem[a[7:0]];
        exp = mem[a[7:0]];
      end
    end
    check(req, "response valid", {31'd0, cpu_rsp_valid}, 1);
    check(req, "response data", cpu_rsp_rdata, exp);
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk);
      check("R11", "response held", {31'd0, cpu_rsp_valid}, 1);
      check("R11", "response data held", cpu_rsp_rdata, exp);
    end
    cpu_rsp_ready = 1;
    @(negedge clk);
    cpu_rsp_ready = 0;
    check("R11", "response consumed", {31'd0, cpu_rsp_valid}, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R11 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0;
    end
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i * 17;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready after reset", {31'd0, cpu_req_ready}, 1);
    check("R1", "no response after reset", {31'd0, cpu_rsp_valid}, 0);
    check("R1", "no bus request after reset", {31'd0, bus_req}, 0);
    do_op("R1", 0, 16'h0007, '0, 0, 0, 0, 0, '0);
    // R2 read miss with slow grant and slow consumer, then R3 hit
    do_op("R2", 0, 16'h0003, '0, 0, 3, 2, 0, '0);
    do_op("R3", 0, 16'h0003, '0, 1, 0, 1, 0, '0);
    // R6 / R8: write hit with own echo, then read hit with new data
    do_op("R6", 1, 16'h0003, 32'h1234_5678, 0, 1, 0, 0, '0);
    do_op("R8", 0, 16'h0003, '0, 1, 0, 0, 0, '0);
    // R5: write miss does not allocate
    do_op("R5", 1, 16'h0020, 32'h0BAD_F00D, 0, 0, 0, 0, '0);
    do_op("R5", 0, 16'h0020, '0, 0, 2, 0, 0, '0);
    // R7: snooped read and same-index other-tag write leave line intact
    snoop(0, 16'h0003, '0);
    do_op("R7", 0, 16'h0003, '0, 1, 0, 0, 0, '0);
    snoop(1, 16'h0013, 32'h5555_0013);
    do_op("R7", 0, 16'h0003, '0, 1, 0, 0, 0, '0);
    // R7: foreign write invalidates, read fetches the new value
    snoop(1, 16'h0003, 32'hCAFE_0003);
    do_op("R7", 0, 16'h0003, '0, 0, 1, 0, 0, '0);
    // R12: conflicting tag displaces the line
    do_op("R12", 0, 16'h0013, '0, 0, 0, 0, 0, '0);
    do_op("R12", 0, 16'h0003, '0, 0, 0, 0, 0, '0);
    do_op("R12", 0, 16'h0003, '0, 1, 0, 0, 0, '0);
    // R9: snooped write on the looked-up line in the same cycle
    do_op("R2", 0, 16'h0005, '0, 0, 0, 0, 0, '0);
    do_op("R9", 0, 16'h0005, '0, 0, 0, 0, 1, 32'h7777_0005);
    do_op("R9", 0, 16'h0005, '0, 1, 0, 0, 0, '0);
    // R4: write miss to a fresh line, zero grant delay
    do_op("R4", 1, 16'h00F1, 32'h0000_00F1, 0, 0, 0, 0, '0);
    do_op("R4", 0, 16'h00F1, '0, 0, 0, 0, 0, '0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule